// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns characters queued in a small internal transmit FIFO into asynchronous serial frames on a single output line. A producer writes characters through a valid/ready handshake. The serializer takes the oldest character whenever it is idle and allowed to start. It sends a start bit, then 5 to 8 data bits least significant bit first, then an optional parity bit, then a stop period of one or one and a half bit times. Bit timing comes from an external 16x oversampling enable, `os_tick_i`. The baud generator that produces it sits outside the block.

Frame format comes from static configuration inputs. The block samples them at the moment a character is taken from the FIFO. Parity can be even, odd, forced high or forced low, and even/odd parity can count either the ones or the zeros in the data. Further controls give a break mode that forces the line low, flow gating on a clear-to-send input with selectable active level, and a flush pulse that discards everything still queued.

Top module: `uart_txf`

## Requirements
- R1: After reset `txd_o` is 1, `busy_o` is 0 and `wr_ready_o` is 1. All configuration inputs at 0 select 5 data bits, no parity, 1 stop bit and no flow gating.
- R2: The idle line is 1. A frame starts with a 0 start bit, then data least significant bit first. Every start, data and parity bit lasts OSR (16) ticks of `os_tick_i`. `txd_o` is registered and follows the internal bit position one clock later.
- R3: `char_size_i` sets the data length: 0 = 5 bits, 1 = 6, 2 = 7, 3 = 8. Data bits above the chosen length are not sent.
- R4: With `par_en_i` = 1, exactly one parity bit follows the last data bit. With `par_en_i` = 0, the stop period follows the data directly.
- R5: `par_kind_i` selects the parity bit: 0 = even (the counted bits plus the parity bit give an even total), 1 = odd, 2 = always 1, 3 = always 0.
- R6: `par_zeros_i` = 0 makes even/odd parity count the ones among the sent data bits. `par_zeros_i` = 1 makes it count the zeros.
- R7: `stop_long_i` = 0 gives a stop period of 16 ticks. `stop_long_i` = 1 gives 24 ticks. A frame holds `busy_o` high for 16*(2+bits+parity) ticks, plus 8 more with the long stop.
- R8: While `brk_i` is 1, `txd_o` is 0 one clock later, at every bit position including start, parity and stop. Frame timing and FIFO draining do not change.
- R9: With `flow_en_i` = 1, a new frame starts only while `cts_i` equals `cts_pol_i`. `cts_pol_i` = 0 means clear-to-send is active low, and 1 means active high.
- R10: A frame that has started always runs to the end of its stop period, even if `cts_i` deasserts during it.
- R11: A one-cycle `flush_i` empties the FIFO. A write offered in the flush cycle is refused (`wr_ready_o` = 0). A frame in progress is not affected.
- R12: The FIFO holds FIFO_DEPTH (4) characters. When it is full, `wr_ready_o` is 0 and the offered character is dropped. Characters go out in the order they were written.
- R13: `busy_o` rises on the clock edge at which a character leaves the FIFO. It falls when the stop period ends. At least one idle cycle separates consecutive frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| os_tick_i | input | 1 | 16x oversampling enable, one pulse per 1/16 bit |
| char_size_i | input | 2 | Data length code (0..3 = 5..8 bits) |
| par_en_i | input | 1 | Append a parity bit |
| par_kind_i | input | 2 | Parity kind: even, odd, one, zero |
| par_zeros_i | input | 1 | Even/odd parity counts zeros instead of ones |
| stop_long_i | input | 1 | 1.5-bit stop period |
| brk_i | input | 1 | Force the line low |
| flow_en_i | input | 1 | Gate frame starts on clear-to-send |
| cts_pol_i | input | 1 | Active level of `cts_i` |
| cts_i | input | 1 | Clear-to-send from the far end |
| flush_i | input | 1 | Discard all queued characters |
| wr_valid_i | input | 1 | Write request into the FIFO |
| wr_data_i | input | DATA_W | Character to queue |
| wr_ready_o | output | 1 | FIFO accepts the write this cycle |
| txd_o | output | 1 | Serial line output |
| busy_o | output | 1 | A frame is being sent |

## Verification
The per-cycle model is driven with every length code and every parity kind crossed with both counting rules. It uses data words whose one and zero counts have different oddness, so a swapped kind or counting rule changes the line. Ticks arrive every cycle in some phases and every third cycle in others, which separates tick-counted timing from clock-counted timing. The short and long stop periods are also timed directly from `busy_o`. Flow gating is tried with both polarities and with CTS dropping in mid-frame. The FIFO is filled past its depth and flushed while blocked, which shows the ordering, the refusal of writes and the loss of the flushed entries. Break is held across a complete frame and the line is checked low at every cycle.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

  // Shortest data length, selected by size code 0.
  localparam int MIN_BITS = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef enum logic [1:0] {
    PAR_EVEN  = 2'd0,
    PAR_ODD   = 2'd1,
    PAR_ONE   = 2'd2,
    PAR_ZERO  = 2'd3
  } par_kind_e;

  typedef struct packed {
    logic [1:0] size;
    logic       par_en;
    par_kind_e  par_kind;
    logic       par_zeros;
    logic       stop_long;
  } frame_cfg_t;

endpackage

// File: rtl/uart_txf_fifo.sv
module uart_txf_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wr_ready_o,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  input  logic          rd_ready_i
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d;
  logic [AW-1:0] rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push, pop;

  // Flush blocks both sides for its cycle so no entry survives it.
  assign wr_ready_o = (cnt_q != CNT_FULL) && !flush_i;
  assign rd_valid_o = (cnt_q != '0) && !flush_i;
  assign rd_data_o  = mem_q[rptr_q];
  assign push       = wr_valid_i & wr_ready_o;
  assign pop        = rd_valid_o & rd_ready_i;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (flush_i) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push) wptr_d = (wptr_q == PTR_LAST) ? '0 : wptr_q + AW'(1);
      if (pop)  rptr_d = (rptr_q == PTR_LAST) ? '0 : rptr_q + AW'(1);
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // Storage has no reset; only the enable guards it.
  always_ff @(posedge clk_i) begin
    if (push) mem_q[wptr_q] <= wr_data_i;
  end

  a_r11_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0));

  a_r12_never_overfilled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);

  a_r12_full_blocks_growth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_FULL) |=> (cnt_q <= CNT_FULL) && !(cnt_q > $past(cnt_q)));

endmodule

// File: rtl/uart_txf_parity.sv
module uart_txf_parity
  import uart_txf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data_i,
  input  logic [1:0]    size_i,
  input  par_kind_e     kind_i,
  input  logic          zeros_i,
  output logic          par_o
);

  logic [DW-1:0] keep;
  logic          ones_odd;
  logic          width_odd;
  logic          count_odd;

  // Mask of the bits that are actually sent for the chosen length.
  for (genvar i = 0; i < DW; i++) begin : g_keep
    if (i < MIN_BITS) begin : g_always
      assign keep[i] = 1'b1;
    end else begin : g_sized
      assign keep[i] = (int'(size_i) + MIN_BITS) > i;
    end
  end

  // Zero count parity = one count parity XOR length parity (5 and 7 are odd).
  assign ones_odd  = ^(data_i & keep);
  assign width_odd = ~size_i[0];
  assign count_odd = ones_odd ^ (zeros_i & width_odd);

  always_comb begin
    case (kind_i)
      PAR_EVEN: par_o = count_odd;
      PAR_ODD:  par_o = ~count_odd;
      PAR_ONE:  par_o = 1'b1;
      default:  par_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/uart_txf_ser.sv
module uart_txf_ser
  import uart_txf_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          os_tick_i,
  input  frame_cfg_t    cfg_i,
  input  logic          flow_en_i,
  input  logic          cts_pol_i,
  input  logic          cts_i,
  input  logic          brk_i,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          rd_ready_o,
  output logic          txd_o,
  output logic          busy_o
);

  localparam int BW = $clog2(DW);
  localparam int TW = $clog2(OSR + OSR / 2);
  localparam logic [TW-1:0] LAST_STD  = TW'(OSR - 1);
  localparam logic [TW-1:0] LAST_LONG = TW'(OSR + OSR / 2 - 1);
  localparam logic [BW-1:0] LAST_MIN  = BW'(MIN_BITS - 1);

  tx_state_e     state_q, state_d;
  logic [TW-1:0] tick_q, tick_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [DW-1:0] shift_q, shift_d;
  logic          par_q, par_d;
  frame_cfg_t    cfg_q, cfg_d;
  logic          txd_q, txd_d;

  logic          cts_ok;
  logic          launch;
  logic          bit_end;
  logic          last_data;
  logic          line_bit;
  logic          par_calc;
  logic [TW-1:0] tick_last;

  uart_txf_parity #(.DW(DW)) u_parity (
    .data_i  (rd_data_i),
    .size_i  (cfg_i.size),
    .kind_i  (cfg_i.par_kind),
    .zeros_i (cfg_i.par_zeros),
    .par_o   (par_calc)
  );

  always_comb begin
    cts_ok     = !flow_en_i || (cts_i == cts_pol_i);
    rd_ready_o = (state_q == ST_IDLE) && cts_ok;
    launch     = rd_ready_o && rd_valid_i;
    tick_last  = (state_q == ST_STOP && cfg_q.stop_long) ? LAST_LONG : LAST_STD;
    bit_end    = os_tick_i && (state_q != ST_IDLE) && (tick_q == tick_last);
    last_data  = (bit_q == (LAST_MIN + BW'(cfg_q.size)));

    state_d = state_q;
    tick_d  = tick_q;
    bit_d   = bit_q;
    shift_d = shift_q;
    par_d   = par_q;
    cfg_d   = cfg_q;

    if (launch || bit_end) begin
      tick_d = '0;
    end else if (os_tick_i && (state_q != ST_IDLE)) begin
      tick_d = tick_q + TW'(1);
    end

    case (state_q)
      ST_IDLE: begin
        if (launch) begin
          state_d = ST_START;
          shift_d = rd_data_i;
          par_d   = par_calc;
          cfg_d   = cfg_i;
          bit_d   = '0;
        end
      end
      ST_START: begin
        if (bit_end) state_d = ST_DATA;
      end
      ST_DATA: begin
        if (bit_end) begin
          shift_d = shift_q >> 1;
          bit_d   = bit_q + BW'(1);
          if (last_data) state_d = cfg_q.par_en ? ST_PAR : ST_STOP;
        end
      end
      ST_PAR: begin
        if (bit_end) state_d = ST_STOP;
      end
      ST_STOP: begin
        if (bit_end) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase

    case (state_q)
      ST_START: line_bit = 1'b0;
      ST_DATA:  line_bit = shift_q[0];
      ST_PAR:   line_bit = par_q;
      default:  line_bit = 1'b1;
    endcase
    txd_d = line_bit & ~brk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tick_q  <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      par_q   <= 1'b0;
      cfg_q   <= '0;
      txd_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      tick_q  <= tick_d;
      bit_q   <= bit_d;
      shift_q <= shift_d;
      par_q   <= par_d;
      cfg_q   <= cfg_d;
      txd_q   <= txd_d;
    end
  end

  assign txd_o  = txd_q;
  assign busy_o = (state_q != ST_IDLE);

  a_r2_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !brk_i) |=> txd_o);

  a_r2_start_bit_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START) |=> !txd_o);

  a_r8_break_forces_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |=> !txd_o);

  a_r7_tick_within_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_STOP) |-> (tick_q <= LAST_STD));

  a_r10_frame_not_aborted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && state_q != ST_STOP) |=> (state_q != ST_IDLE));

endmodule

// File: rtl/uart_txf.sv
module uart_txf
  import uart_txf_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int OSR        = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              os_tick_i,
  input  logic [1:0]        char_size_i,
  input  logic              par_en_i,
  input  logic [1:0]        par_kind_i,
  input  logic              par_zeros_i,
  input  logic              stop_long_i,
  input  logic              brk_i,
  input  logic              flow_en_i,
  input  logic              cts_pol_i,
  input  logic              cts_i,
  input  logic              flush_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_ready_o,
  output logic              txd_o,
  output logic              busy_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  frame_cfg_t        cfg;
  logic              fifo_valid;
  logic [DATA_W-1:0] fifo_data;
  logic              ser_ready;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    cfg.size      = char_size_i;
    cfg.par_en    = par_en_i;
    cfg.par_kind  = par_kind_e'(par_kind_i);
    cfg.par_zeros = par_zeros_i;
    cfg.stop_long = stop_long_i;
  end

  uart_txf_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .flush_i    (flush_i),
    .wr_valid_i (wr_valid_i),
    .wr_data_i  (wr_data_i),
    .wr_ready_o (wr_ready_o),
    .rd_valid_o (fifo_valid),
    .rd_data_o  (fifo_data),
    .rd_ready_i (ser_ready)
  );

  uart_txf_ser #(.DW(DATA_W), .OSR(OSR)) u_ser (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .os_tick_i  (os_tick_i),
    .cfg_i      (cfg),
    .flow_en_i  (flow_en_i),
    .cts_pol_i  (cts_pol_i),
    .cts_i      (cts_i),
    .brk_i      (brk_i),
    .rd_valid_i (fifo_valid),
    .rd_data_i  (fifo_data),
    .rd_ready_o (ser_ready),
    .txd_o      (txd_o),
    .busy_o     (busy_o)
  );

  a_r13_busy_after_pop: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (fifo_valid && ser_ready) |=> busy_o);

  a_r9_blocked_stays_idle: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (!busy_o && flow_en_i && (cts_i != cts_pol_i)) |=> !busy_o);

endmodule

// File: tb/tb_uart_txf.sv
`timescale 1ns/1ps
module tb_uart_txf;

  localparam int DW    = 8;
  localparam int DEPTH = 4;
  localparam int OSR   = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          os_tick;
  logic [1:0]    char_size;
  logic          par_en;
  logic [1:0]    par_kind;
  logic          par_zeros;
  logic          stop_long;
  logic          brk;
  logic          flow_en;
  logic          cts_pol;
  logic          cts;
  logic          flush;
  logic          wr_valid;
  logic [DW-1:0] wr_data;
  logic          wr_ready_o;
  logic          txd_o;
  logic          busy_o;

  always #2 clk = ~clk;

  uart_txf #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .OSR(OSR)) dut (
    .clk_i(clk), .rst_ni(rst_n), .os_tick_i(os_tick),
    .char_size_i(char_size), .par_en_i(par_en), .par_kind_i(par_kind),
    .par_zeros_i(par_zeros), .stop_long_i(stop_long), .brk_i(brk),
    .flow_en_i(flow_en), .cts_pol_i(cts_pol), .cts_i(cts), .flush_i(flush),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready_o),
    .txd_o(txd_o), .busy_o(busy_o)
  );

  int    n_vec  = 0;
  int    n_miss = 0;
  string cur_req = "R1";
  int    tick_every = 1;
  int    tick_ctr = 0;
  int    cycles = 0;

  // ---------------- behavioural reference ----------------
  logic [7:0] q[$];
  int         m_state;   // 0 idle, 1 start, 2 data, 3 parity, 4 stop
  int         m_tick;
  int         m_bit;
  int         m_nbits;
  logic [7:0] m_sh;
  logic       m_par;
  logic       m_paren;
  logic       m_long;
  logic       m_txd;

  function automatic logic ref_parity(logic [7:0] d, int nb, int kind, logic zeros);
    int ones = 0;
    int cnt;
    for (int i = 0; i < nb; i++) if (d[i]) ones++;
    cnt = zeros ? (nb - ones) : ones;
    case (kind)
      0: return logic'(cnt % 2);
      1: return logic'(1 - cnt % 2);
      2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_state = 0; m_tick = 0; m_bit = 0; m_nbits = 5;
      m_sh = '0; m_par = 0; m_paren = 0; m_long = 0; m_txd = 1;
    end else begin
      logic line;
      logic ok;
      logic launch;
      logic do_push;
      int   last;
      logic bend;
      case (m_state)
        1: line = 1'b0;
        2: line = m_sh[0];
        3: line = m_par;
        default: line = 1'b1;
      endcase
      ok      = !flow_en || (cts == cts_pol);
      launch  = (m_state == 0) && ok && (q.size() > 0) && !flush;
      do_push = wr_valid && (q.size() < DEPTH) && !flush;
      last    = (m_state == 4 && m_long) ? (OSR + OSR/2 - 1) : (OSR - 1);
      bend    = os_tick && (m_state != 0) && (m_tick == last);
      if (launch) begin
        m_sh    = q.pop_front();
        m_nbits = 5 + int'(char_size);
        m_paren = par_en;
        m_long  = stop_long;
        m_par   = ref_parity(m_sh, m_nbits, int'(par_kind), par_zeros);
        m_state = 1; m_tick = 0; m_bit = 0;
      end else if (m_state != 0) begin
        if (bend) begin
          m_tick = 0;
          case (m_state)
            1: m_state = 2;
            2: begin
              m_sh = m_sh >> 1;
              if (m_bit == m_nbits - 1) m_state = m_paren ? 3 : 4;
              m_bit++;
            end
            3: m_state = 4;
            default: m_state = 0;
          endcase
        end else if (os_tick) begin
          m_tick++;
        end
      end
      if (flush) q.delete();
      else if (do_push) q.push_back(wr_data);
      m_txd = line & ~brk;
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      logic exp_rdy;
      logic exp_busy;
      exp_rdy  = (q.size() < DEPTH) && !flush;
      exp_busy = (m_state != 0);
      n_vec++;
      if (txd_o !== m_txd || busy_o !== exp_busy || wr_ready_o !== exp_rdy) begin
        n_miss++;
        $display("FAIL %s t=%0t txd/busy/ready actual %b%b%b expected %b%b%b",
                 cur_req, $time, txd_o, busy_o, wr_ready_o, m_txd, exp_busy, exp_rdy);
      end
    end
  end

  // Oversampling enable, changed just after each rising edge.
  always @(posedge clk) begin
    #1;
    tick_ctr++;
    os_tick = (tick_every <= 1) ? 1'b1 : ((tick_ctr % tick_every) == 0);
  end

  // ---------------- helpers ----------------
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_bit(string req, string what, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_miss++;
      $display("FAIL %s %s actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic push(logic [7:0] d);
    wr_valid = 1'b1; wr_data = d;
    step();
    wr_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((m_state != 0 || q.size() != 0) && n < 20000) begin step(); n++; end
    step();
  endtask

  task automatic set_fmt(int sz, logic pe, int pk, logic pz, logic sl);
    char_size = 2'(sz); par_en = pe; par_kind = 2'(pk); par_zeros = pz; stop_long = sl;
  endtask

  // Push one character and time busy_o in clocks (tick every clock).
  task automatic time_frame(logic [7:0] d, string req, int exp_len);
    int len = 0;
    push(d);
    forever begin
      @(negedge clk);
      if (busy_o) len++;
      else if (len > 0) break;
    end
    @(posedge clk); #1;
    n_vec++;
    if (len != exp_len) begin
      n_miss++;
      $display("FAIL %s frame length actual %0d expected %0d", req, len, exp_len);
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_miss++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; os_tick = 1'b0;
    set_fmt(0, 0, 0, 0, 0);
    brk = 0; flow_en = 0; cts_pol = 0; cts = 0; flush = 0;
    wr_valid = 0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) step();

    // R1: reset state and default format
    cur_req = "R1";
    @(negedge clk);
    expect_bit("R1", "txd", txd_o, 1'b1);
    expect_bit("R1", "busy", busy_o, 1'b0);
    expect_bit("R1", "wr_ready", wr_ready_o, 1'b1);
    @(posedge clk); #1;
    time_frame(8'hA5, "R1", OSR * 7);

    // R2: bit order and tick pacing, ticks every cycle then sparse
    cur_req = "R2";
    set_fmt(3, 0, 0, 0, 0);
    push(8'h01); push(8'h80); wait_idle();
    tick_every = 3;
    push(8'h6C); wait_idle();
    tick_every = 1;

    // R3: every length code; upper bits must not appear
    cur_req = "R3";
    for (int s = 0; s < 4; s++) begin
      set_fmt(s, 0, 0, 0, 0);
      push(8'hE6); wait_idle();
      time_frame(8'h1F, "R3", OSR * (7 + s));
    end

    // R4: parity slot present and absent
    cur_req = "R4";
    set_fmt(1, 1, 0, 0, 0);
    time_frame(8'h2B, "R4", OSR * 9);
    set_fmt(1, 0, 0, 0, 0);
    push(8'h2B); wait_idle();

    // R5 / R6: every kind crossed with both counting rules
    for (int z = 0; z < 2; z++) begin
      cur_req = (z == 0) ? "R5" : "R6";
      for (int k = 0; k < 4; k++) begin
        set_fmt(3, 1, k, logic'(z), 0);
        push(8'h5B); push(8'h07); wait_idle();
        set_fmt(0, 1, k, logic'(z), 0);
        push(8'hF4); wait_idle();
        set_fmt(2, 1, k, logic'(z), 0);
        push(8'h13); wait_idle();
      end
    end

    // R7: long stop, timed and back to back with sparse ticks
    cur_req = "R7";
    set_fmt(0, 0, 0, 0, 1);
    time_frame(8'h0A, "R7", OSR * 6 + OSR + OSR / 2);
    set_fmt(0, 0, 0, 0, 0);
    time_frame(8'h0A, "R7", OSR * 7);
    set_fmt(2, 1, 1, 0, 1);
    tick_every = 3;
    push(8'h55); push(8'hAA); wait_idle();
    tick_every = 1;

    // R12 / R9: fill while blocked (active-low CTS held high)
    cur_req = "R12";
    set_fmt(3, 0, 0, 0, 0);
    flow_en = 1; cts_pol = 0; cts = 1;
    push(8'h11); push(8'h22); push(8'h33); push(8'h44);
    @(negedge clk);
    expect_bit("R12", "wr_ready when full", wr_ready_o, 1'b0);
    @(posedge clk); #1;
    push(8'h99);
    cur_req = "R9";
    repeat (60) step();
    @(negedge clk);
    expect_bit("R9", "busy while CTS inactive", busy_o, 1'b0);
    @(posedge clk); #1;
    cts = 0;
    wait_idle();
    cts_pol = 1; cts = 0;
    push(8'h3E);
    repeat (30) step();
    @(negedge clk);
    expect_bit("R9", "busy while CTS inactive high-pol", busy_o, 1'b0);
    @(posedge clk); #1;
    cts = 1;
    wait_idle();

    // R10: CTS drops in mid-frame
    cur_req = "R10";
    push(8'hC3); push(8'h3C);
    repeat (40) step();
    cts = 0;
    repeat (200) step();
    @(negedge clk);
    expect_bit("R10", "frame finished, next held", busy_o, 1'b0);
    @(posedge clk); #1;
    cts = 1;
    wait_idle();

    // R11: flush while blocked, and flush during a frame
    cur_req = "R11";
    cts = 0;
    push(8'h01); push(8'h02); push(8'h03);
    flush = 1; wr_valid = 1; wr_data = 8'h77;
    @(negedge clk);
    expect_bit("R11", "wr_ready during flush", wr_ready_o, 1'b0);
    @(posedge clk); #1;
    flush = 0; wr_valid = 0;
    cts = 1;
    repeat (40) step();
    @(negedge clk);
    expect_bit("R11", "busy after flush", busy_o, 1'b0);
    @(posedge clk); #1;
    push(8'hB7); push(8'h48);
    repeat (20) step();
    flush = 1; step(); flush = 0;
    wait_idle();
    flow_en = 0;

    // R13: busy edges over consecutive frames, sparse ticks
    cur_req = "R13";
    set_fmt(1, 1, 2, 0, 1);
    tick_every = 2;
    push(8'h0F); push(8'hF0); push(8'h33); wait_idle();
    tick_every = 1;

    // R8: break across a full frame
    cur_req = "R8";
    set_fmt(3, 1, 2, 0, 1);
    brk = 1;
    push(8'hFF);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      expect_bit("R8", "txd under break", txd_o, 1'b0);
    end
    @(posedge clk); #1;
    brk = 0;
    wait_idle();
    push(8'hFF); wait_idle();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

endmodule